// File: doc/BRIEF.md
# Floppy Controller Host Status Handshake

This block is the host-facing register front end of a floppy disk controller. It keeps the main status byte and walks it through three phases. In the command phase the host writes bytes. In the execution phase a transfer runs, either by DMA or byte by byte through the data port. In the result phase the host reads status bytes back. The phase is not held in a separate variable. It is carried by four status flags: ready-for-master, data-direction, non-DMA execution and command-busy. Those same flags decide whether each data-port access is allowed.

The block also holds the data-rate register, whose power-down bit it keeps, and the digital output register, whose controller-run and DMA-enable bits it keeps. A stub outside the block supplies the command length, the result length, the execution style, the transfer length and the bytes the host reads. A DMA completion pulse ends a DMA execution. Any legal host access wakes the controller from power-down.

Top module: `fdc_host_handshake`

## Requirements
- R1: After hard reset the main status byte reads 0x80 (ready-for-master, bit 7, alone), `dataPos` is 0, `irq` is low, `pwrDown` is low and the output register reads 0x0C (run bit 2 and DMA-enable bit 3 set).
- R2: A data-port read (regSel 2) is legal only when status bits 7 and 6 are both set. An illegal read returns 0 and changes no state.
- R3: A data-port write is legal only when status bit 7 is set, bit 6 is clear and output-register bit 2 is set. Any other data-port write is ignored.
- R4: Legal command-phase writes advance `dataPos`. Bit 7 of the byte written at position 0 sets `multiTrack`. The byte that brings the count to `cmdLen` starts execution according to `xferMode`: 0 or 3 means no data phase, 1 means DMA, 2 means port-driven.
- R5: Entering the result phase loads the result length, zeroes `dataPos`, makes the status byte 0xD0 (bits 7, 6 and 4 set, bit 5 clear) and raises `irq`. With `xferMode` 0 it is entered on the last command byte with length `resLen`.
- R6: A legal result-phase read returns `stubData` and advances `dataPos`. The read at position 0 drops `irq`. After the last result byte the status byte returns to 0x80 and `dataPos` to 0.
- R7: Starting a DMA execution sets the status byte to 0x10 (busy only), which locks out the data port. A `dmaDone` pulse while bit 7 is clear and bit 4 is set enters a 7-byte result phase with `irq`. At any other time `dmaDone` is ignored.
- R8: Starting a port-driven execution sets bits 5 and 4 and loads `xferLen`. The status byte is 0xB0 when host-to-controller (`xferDir` 0) and 0xF0 when controller-to-host. Once `xferLen` bytes have moved, a 7-byte result phase is entered with `irq`.
- R9: Reading the status byte (regSel 1) clears `pwrDown` and forces output-register bit 2 high, without resetting the controller.
- R10: A legal data-port read or write clears `pwrDown`.
- R11: Writing the data-rate register (regSel 1) with bit 6 set resets the controller state (status 0x80, `dataPos` 0, `irq` low, `multiTrack` low). The written bit 6 then appears on `pwrDown`. A write with bit 6 clear causes no reset.
- R12: Writes to the output register (regSel 0) are stored and read back, and `dmaEnable` follows bit 3. A write that takes bit 2 from 0 to 1 resets the controller state and clears `pwrDown`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset |
| hostRd | input | 1 | Host read strobe, one cycle per access |
| hostWr | input | 1 | Host write strobe, ignored when hostRd is high |
| regSel | input | 2 | 0 output register, 1 status read / data-rate write, 2 data port |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data, combinational while hostRd is high |
| cmdLen | input | 8 | Stub: command length in bytes |
| resLen | input | 8 | Stub: result length when no data phase |
| xferMode | input | 2 | Stub: execution style |
| xferDir | input | 1 | Stub: 1 means controller-to-host for port-driven execution |
| xferLen | input | 8 | Stub: port-driven transfer length |
| stubData | input | 8 | Stub: byte returned on a legal data read |
| dmaDone | input | 1 | DMA completion pulse |
| irq | output | 1 | Interrupt level |
| multiTrack | output | 1 | Multi-track flag from the first command byte |
| dataPos | output | 8 | Byte position within the current phase |
| pwrDown | output | 1 | Power-down bit of the data-rate register |
| dmaEnable | output | 1 | DMA-enable bit of the output register |

## Verification
Read data is combinational: `rdData` is due in the same cycle as `hostRd`. The bench drives each access at the falling edge and samples `rdData` one time step later, before the rising edge. Every registered effect of an access lands at the following rising edge: status bits, `dataPos`, `irq`, `multiTrack`, `pwrDown`, the output register and a controller reset. The bench samples those one time step after that edge, and it drops the strobes at the same point so that no access lasts longer than one edge. The bench model is updated with the same one-edge latency, so every comparison lines up with the cycle in which the requirement says the change appears.

// File: rtl/fdc_hs_pkg.sv
package fdc_hs_pkg;
  // status byte flag positions
  localparam int MSR_RQM    = 7;
  localparam int MSR_DIO    = 6;
  localparam int MSR_NONDMA = 5;
  localparam int MSR_BUSY   = 4;
  // data-rate register power-down position
  localparam int DSR_PWRDN  = 6;
  // output register positions
  localparam int DOR_NRST   = 2;
  localparam int DOR_DMAEN  = 3;

  typedef enum logic [1:0] {
    SEL_DOR  = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_DMA  = 2'd1,
    XF_PIO  = 2'd2,
    XF_RSVD = 2'd3
  } xferMode_e;

  typedef struct packed {
    logic ctlReset;
    logic enterResult;
    logic enterCommand;
    logic startDma;
    logic startPio;
    logic pioToHost;
    logic posInc;
    logic clrIrq;
    logic captureMulti;
    logic clrPwrDn;
    logic dsrWr;
    logic dorWr;
    logic dorForceRun;
  } strobe_t;
endpackage

// File: rtl/fdc_hs_ctrl.sv
module fdc_hs_ctrl
  import fdc_hs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 8,
  parameter int RESULT_LEN = 7
) (
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [7:0]        msrQ,
  input  logic [DATA_W-1:0] dorQ,
  input  logic [LEN_W-1:0]  dataPos,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [LEN_W-1:0]  resLen,
  input  logic [1:0]        xferMode,
  input  logic              xferDir,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic              dmaDone,
  output strobe_t           stb,
  output logic [LEN_W-1:0]  newLen,
  output logic              rdLegal
);
  localparam logic [LEN_W-1:0] RES_LEN_C = LEN_W'(RESULT_LEN);

  logic rqm, dio, nonDma, busy;
  logic selData, wrAny, wrLegal, mainRd, dsrW, dorW, dorRise;
  logic dmaFinish, lastByte, cmdDone;
  logic [LEN_W:0] posNext;

  assign rqm    = msrQ[MSR_RQM];
  assign dio    = msrQ[MSR_DIO];
  assign nonDma = msrQ[MSR_NONDMA];
  assign busy   = msrQ[MSR_BUSY];

  assign selData  = (regSel == SEL_DATA);
  assign wrAny    = hostWr && !hostRd;
  assign rdLegal  = hostRd && selData && rqm && dio;
  assign wrLegal  = wrAny && selData && rqm && !dio && dorQ[DOR_NRST];
  assign mainRd   = hostRd && (regSel == SEL_MAIN);
  assign dsrW     = wrAny && (regSel == SEL_MAIN);
  assign dorW     = wrAny && (regSel == SEL_DOR);
  assign dorRise  = dorW && !dorQ[DOR_NRST] && wrData[DOR_NRST];
  assign dmaFinish = dmaDone && busy && !rqm;

  assign posNext  = {1'b0, dataPos} + 1'b1;
  assign lastByte = posNext >= {1'b0, dataLen};
  assign cmdDone  = posNext >= {1'b0, cmdLen};

  always_comb begin
    stb = '0;
    newLen = '0;
    stb.ctlReset    = (dsrW && wrData[DSR_PWRDN]) || dorRise;
    stb.clrPwrDn    = rdLegal || wrLegal || mainRd || dorRise;
    stb.dsrWr       = dsrW;
    stb.dorWr       = dorW;
    stb.dorForceRun = mainRd;
    stb.pioToHost   = xferDir;
    if (dmaFinish) begin
      stb.enterResult = 1'b1;
      newLen = RES_LEN_C;
    end else if (rdLegal) begin
      stb.posInc = 1'b1;
      if (nonDma) begin
        if (lastByte) begin
          stb.enterResult = 1'b1;
          newLen = RES_LEN_C;
        end
      end else begin
        stb.clrIrq = (dataPos == '0);
        stb.enterCommand = lastByte;
      end
    end else if (wrLegal) begin
      stb.posInc = 1'b1;
      if (nonDma) begin
        if (lastByte) begin
          stb.enterResult = 1'b1;
          newLen = RES_LEN_C;
        end
      end else begin
        stb.captureMulti = (dataPos == '0);
        if (cmdDone) begin
          case (xferMode)
            XF_DMA: stb.startDma = 1'b1;
            XF_PIO: begin
              stb.startPio = 1'b1;
              newLen = xferLen;
            end
            default: begin
              stb.enterResult = 1'b1;
              newLen = resLen;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fdc_hs_dp.sv
module fdc_hs_dp
  import fdc_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 8,
  parameter bit DMA_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [LEN_W-1:0]  newLen,
  input  logic [DATA_W-1:0] wrData,
  output logic [7:0]        msrQ,
  output logic [DATA_W-1:0] dorQ,
  output logic [DATA_W-1:0] dsrQ,
  output logic [LEN_W-1:0]  dataPos,
  output logic [LEN_W-1:0]  dataLen,
  output logic              irq,
  output logic              multiTrack
);
  localparam logic [7:0] MSR_IDLE = 8'h80;
  localparam logic [DATA_W-1:0] DOR_INIT =
    DATA_W'((1 << DOR_NRST) | (int'(DMA_PRESENT) << DOR_DMAEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msrQ       <= MSR_IDLE;
      dataPos    <= '0;
      dataLen    <= '0;
      irq        <= 1'b0;
      multiTrack <= 1'b0;
      dsrQ       <= '0;
      dorQ       <= DOR_INIT;
    end else begin
      if (stb.ctlReset) begin
        msrQ       <= MSR_IDLE;
        dataPos    <= '0;
        dataLen    <= '0;
        irq        <= 1'b0;
        multiTrack <= 1'b0;
      end else begin
        if (stb.enterResult) begin
          dataLen            <= newLen;
          dataPos            <= '0;
          msrQ[MSR_RQM]      <= 1'b1;
          msrQ[MSR_DIO]      <= 1'b1;
          msrQ[MSR_BUSY]     <= 1'b1;
          msrQ[MSR_NONDMA]   <= 1'b0;
          irq                <= 1'b1;
        end else if (stb.enterCommand) begin
          dataPos        <= '0;
          msrQ[MSR_BUSY] <= 1'b0;
          msrQ[MSR_DIO]  <= 1'b0;
        end else if (stb.startDma) begin
          dataPos        <= '0;
          msrQ[MSR_BUSY] <= 1'b1;
          msrQ[MSR_RQM]  <= 1'b0;
        end else if (stb.startPio) begin
          dataPos          <= '0;
          dataLen          <= newLen;
          msrQ[MSR_BUSY]   <= 1'b1;
          msrQ[MSR_NONDMA] <= 1'b1;
          if (stb.pioToHost) msrQ[MSR_DIO] <= 1'b1;
        end else if (stb.posInc) begin
          dataPos <= dataPos + 1'b1;
        end
        if (stb.clrIrq && !stb.enterResult) irq <= 1'b0;
        if (stb.captureMulti) multiTrack <= wrData[DATA_W-1];
      end
      if (stb.dsrWr) dsrQ <= wrData;
      else if (stb.clrPwrDn) dsrQ[DSR_PWRDN] <= 1'b0;
      if (stb.dorWr) dorQ <= wrData;
      else if (stb.dorForceRun) dorQ[DOR_NRST] <= 1'b1;
    end
  end

  AST_RESULT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.enterResult && !stb.ctlReset) |=> (msrQ[7:4] == 4'b1101 && dataPos == '0 && irq)); // R5
  AST_CTL_RESET: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctlReset |=> (msrQ == MSR_IDLE && dataPos == '0 && !irq && !multiTrack)); // R11
  AST_DMA_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (stb.startDma && !stb.ctlReset) |=> (!msrQ[MSR_RQM] && msrQ[MSR_BUSY])); // R7
  AST_DSR_STORE: assert property (@(posedge clk) disable iff (!rstN)
    stb.dsrWr |=> (dsrQ[DSR_PWRDN] == $past(wrData[DSR_PWRDN]))); // R11
endmodule

// File: rtl/fdc_host_handshake.sv
module fdc_host_handshake
  import fdc_hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 8,
  parameter int RESULT_LEN  = 7,
  parameter bit DMA_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [LEN_W-1:0]  resLen,
  input  logic [1:0]        xferMode,
  input  logic              xferDir,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [DATA_W-1:0] stubData,
  input  logic              dmaDone,
  output logic              irq,
  output logic              multiTrack,
  output logic [LEN_W-1:0]  dataPos,
  output logic              pwrDown,
  output logic              dmaEnable
);
  strobe_t            stb;
  logic [LEN_W-1:0]   newLen;
  logic               rdLegal;
  logic [7:0]         msrQ;
  logic [DATA_W-1:0]  dorQ;
  logic [DATA_W-1:0]  dsrQ;
  logic [LEN_W-1:0]   dataLen;

  fdc_hs_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .RESULT_LEN(RESULT_LEN)) i_ctrl (
    .hostRd(hostRd), .hostWr(hostWr), .regSel(regSel), .wrData(wrData),
    .msrQ(msrQ), .dorQ(dorQ), .dataPos(dataPos), .dataLen(dataLen),
    .cmdLen(cmdLen), .resLen(resLen), .xferMode(xferMode), .xferDir(xferDir),
    .xferLen(xferLen), .dmaDone(dmaDone), .stb(stb), .newLen(newLen),
    .rdLegal(rdLegal)
  );

  fdc_hs_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DMA_PRESENT(DMA_PRESENT)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .newLen(newLen), .wrData(wrData),
    .msrQ(msrQ), .dorQ(dorQ), .dsrQ(dsrQ), .dataPos(dataPos),
    .dataLen(dataLen), .irq(irq), .multiTrack(multiTrack)
  );

  always_comb begin
    rdData = '0;
    if (hostRd) begin
      case (regSel)
        SEL_DOR:  rdData = dorQ;
        SEL_MAIN: rdData = DATA_W'(msrQ);
        SEL_DATA: rdData = rdLegal ? stubData : '0;
        default:  rdData = '0;
      endcase
    end
  end

  assign pwrDown   = dsrQ[DSR_PWRDN];
  assign dmaEnable = dorQ[DOR_DMAEN];

  AST_ILLEGAL_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && regSel == SEL_DATA && !(msrQ[MSR_RQM] && msrQ[MSR_DIO])) |-> (rdData == '0)); // R2
  AST_ILLEGAL_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && regSel == SEL_DATA && !(msrQ[MSR_RQM] && msrQ[MSR_DIO]) && !dmaDone)
      |=> ($stable(dataPos) && $stable(msrQ))); // R2
  AST_MSR_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && regSel == SEL_MAIN) |=> (!pwrDown && dorQ[DOR_NRST])); // R9
  AST_STRAY_DMA_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDone && msrQ[MSR_RQM] && !hostRd && !hostWr) |=> $stable(msrQ)); // R7
endmodule

// File: tb/test_fdc_host_handshake.sv
module test_fdc_host_handshake;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRd = 1'b0, hostWr = 1'b0, xferDir = 1'b0, dmaDone = 1'b0;
  logic [1:0] regSel = 2'd0, xferMode = 2'd0;
  logic [7:0] wrData = 8'h00, cmdLen = 8'd1, resLen = 8'd1, xferLen = 8'd1, stubData = 8'h00;
  logic [7:0] rdData, dataPos;
  logic irq, multiTrack, pwrDown, dmaEnable;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] mMsr, mDor, mLen, mPos;
  bit mIrq, mMulti, mPwr;

  always #5 clk = ~clk;

  fdc_host_handshake i_fdc_host_handshake (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .cmdLen(cmdLen), .resLen(resLen),
    .xferMode(xferMode), .xferDir(xferDir), .xferLen(xferLen), .stubData(stubData),
    .dmaDone(dmaDone), .irq(irq), .multiTrack(multiTrack), .dataPos(dataPos),
    .pwrDown(pwrDown), .dmaEnable(dmaEnable)
  );

  function automatic void check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  function automatic void ctlResetModel();
    mMsr = 8'h80; mPos = 8'h00; mLen = 8'h00; mIrq = 1'b0; mMulti = 1'b0;
  endfunction

  function automatic void enterRes(logic [7:0] n);
    mLen = n; mPos = 8'h00; mMsr[7] = 1'b1; mMsr[6] = 1'b1; mMsr[5] = 1'b0; mMsr[4] = 1'b1;
    mIrq = 1'b1;
  endfunction

  function automatic logic [7:0] modelStep(bit rd, bit wr, logic [1:0] sel, logic [7:0] d, bit dd);
    logic [7:0] expRd;
    bit rqm, dio, nondma, busy, wrEff, rst;
    logic [8:0] nxt;
    rqm = mMsr[7]; dio = mMsr[6]; nondma = mMsr[5]; busy = mMsr[4];
    wrEff = wr && !rd;
    expRd = 8'h00;
    if (rd) begin
      case (sel)
        2'd0: expRd = mDor;
        2'd1: expRd = mMsr;
        2'd2: if (rqm && dio) expRd = stubData;
        default: expRd = 8'h00;
      endcase
    end
    rst = (wrEff && sel == 2'd1 && d[6]) || (wrEff && sel == 2'd0 && !mDor[2] && d[2]);
    nxt = {1'b0, mPos} + 9'd1;
    if (rst) ctlResetModel();
    else if (dd && busy && !rqm) enterRes(8'd7);
    else if (rd && sel == 2'd2 && rqm && dio) begin
      mPwr = 1'b0;
      if (nondma) begin
        if (nxt >= {1'b0, mLen}) enterRes(8'd7); else mPos++;
      end else begin
        if (mPos == 8'h00) mIrq = 1'b0;
        if (nxt >= {1'b0, mLen}) begin
          mPos = 8'h00; mMsr[4] = 1'b0; mMsr[6] = 1'b0;
        end else mPos++;
      end
    end else if (wrEff && sel == 2'd2 && rqm && !dio && mDor[2]) begin
      mPwr = 1'b0;
      if (nondma) begin
        if (nxt >= {1'b0, mLen}) enterRes(8'd7); else mPos++;
      end else begin
        if (mPos == 8'h00) mMulti = d[7];
        if (nxt >= {1'b0, cmdLen}) begin
          case (xferMode)
            2'd1: begin mMsr[4] = 1'b1; mMsr[7] = 1'b0; mPos = 8'h00; end
            2'd2: begin
              mMsr[4] = 1'b1; mMsr[5] = 1'b1; if (xferDir) mMsr[6] = 1'b1;
              mLen = xferLen; mPos = 8'h00;
            end
            default: enterRes(resLen);
          endcase
        end else mPos++;
      end
    end
    if (rd && sel == 2'd1) begin mPwr = 1'b0; mDor[2] = 1'b1; end
    if (wrEff && sel == 2'd1) mPwr = d[6];
    if (wrEff && sel == 2'd0) begin
      if (!mDor[2] && d[2]) mPwr = 1'b0;
      mDor = d;
    end
    return expRd;
  endfunction

  task automatic step(string tag, bit rd, bit wr, logic [1:0] sel, logic [7:0] d, bit dd);
    logic [7:0] expRd;
    @(negedge clk);
    hostRd = rd; hostWr = wr; regSel = sel; wrData = d; dmaDone = dd;
    stubData = 8'($urandom);
    #1;
    expRd = modelStep(rd, wr, sel, d, dd);
    if (rd) check(tag, "rdData", rdData, expRd);
    @(posedge clk);
    #1;
    hostRd = 1'b0; hostWr = 1'b0; dmaDone = 1'b0;
    check(tag, "irq", 8'(irq), 8'(mIrq));
    check(tag, "dataPos", dataPos, mPos);
    check(tag, "pwrDown", 8'(pwrDown), 8'(mPwr));
    check(tag, "multiTrack", 8'(multiTrack), 8'(mMulti));
    check(tag, "dmaEnable", 8'(dmaEnable), 8'(mDor[3]));
  endtask

  task automatic setStub(logic [7:0] cl, logic [7:0] rl, logic [1:0] md, bit dr, logic [7:0] xl);
    cmdLen = cl; resLen = rl; xferMode = md; xferDir = dr; xferLen = xl;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    mDor = 8'h0C; mPwr = 1'b0;
    ctlResetModel();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1", "dataPos", dataPos, 8'h00);
    check("R1", "irq", 8'(irq), 8'h00);
    step("R1", 1, 0, 2'd1, 8'h00, 0);
    step("R1", 1, 0, 2'd0, 8'h00, 0);
    // R2 illegal read in command phase
    step("R2", 1, 0, 2'd2, 8'h00, 0);
    // R4 / R5 two-byte command, no data phase, two result bytes
    setStub(8'd2, 8'd2, 2'd0, 1'b0, 8'd1);
    step("R4", 0, 1, 2'd2, 8'h85, 0);
    step("R4", 0, 1, 2'd2, 8'h01, 0);
    step("R5", 1, 0, 2'd1, 8'h00, 0);
    check("R5", "irq", 8'(irq), 8'h01);
    step("R3", 0, 1, 2'd2, 8'h33, 0);
    step("R6", 1, 0, 2'd2, 8'h00, 0);
    step("R6", 1, 0, 2'd2, 8'h00, 0);
    step("R6", 1, 0, 2'd1, 8'h00, 0);
    // R7 DMA execution
    setStub(8'd1, 8'd1, 2'd1, 1'b0, 8'd1);
    step("R7", 0, 1, 2'd2, 8'h06, 0);
    step("R7", 1, 0, 2'd1, 8'h00, 0);
    step("R7", 1, 0, 2'd2, 8'h00, 0);
    step("R7", 0, 1, 2'd2, 8'h11, 0);
    step("R7", 0, 0, 2'd0, 8'h00, 1);
    step("R7", 1, 0, 2'd1, 8'h00, 0);
    step("R7", 0, 0, 2'd0, 8'h00, 1);
    for (int i = 0; i < 7; i++) step("R6", 1, 0, 2'd2, 8'h00, 0);
    // R8 port-driven read then write
    setStub(8'd1, 8'd1, 2'd2, 1'b1, 8'd2);
    step("R8", 0, 1, 2'd2, 8'h46, 0);
    step("R8", 1, 0, 2'd1, 8'h00, 0);
    step("R8", 1, 0, 2'd2, 8'h00, 0);
    step("R8", 1, 0, 2'd2, 8'h00, 0);
    step("R8", 1, 0, 2'd1, 8'h00, 0);
    for (int i = 0; i < 7; i++) step("R6", 1, 0, 2'd2, 8'h00, 0);
    setStub(8'd1, 8'd1, 2'd2, 1'b0, 8'd3);
    step("R8", 0, 1, 2'd2, 8'h45, 0);
    step("R8", 1, 0, 2'd1, 8'h00, 0);
    for (int i = 0; i < 3; i++) step("R8", 0, 1, 2'd2, 8'hA0, 0);
    step("R8", 1, 0, 2'd1, 8'h00, 0);
    for (int i = 0; i < 7; i++) step("R6", 1, 0, 2'd2, 8'h00, 0);
    // R9 .. R12 power-down and output register
    step("R11", 0, 1, 2'd1, 8'h40, 0);
    check("R11", "pwrDown", 8'(pwrDown), 8'h01);
    step("R9", 1, 0, 2'd1, 8'h00, 0);
    step("R11", 0, 1, 2'd1, 8'h40, 0);
    setStub(8'd3, 8'd1, 2'd0, 1'b0, 8'd1);
    step("R10", 0, 1, 2'd2, 8'h80, 0);
    step("R11", 0, 1, 2'd1, 8'h02, 0);
    step("R11", 1, 0, 2'd1, 8'h00, 0);
    step("R12", 0, 1, 2'd0, 8'h00, 0);
    step("R3", 0, 1, 2'd2, 8'h12, 0);
    step("R12", 1, 0, 2'd0, 8'h00, 0);
    step("R12", 0, 1, 2'd0, 8'h04, 0);
    step("R12", 1, 0, 2'd1, 8'h00, 0);
    step("R12", 0, 1, 2'd0, 8'h0C, 0);
    step("R12", 1, 0, 2'd0, 8'h00, 0);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom % 100);
      d = 8'($urandom);
      if (mMsr == 8'h80 && mPos == 8'h00)
        setStub(8'(1 + $urandom % 3), 8'(1 + $urandom % 3), 2'($urandom % 4),
                1'($urandom % 2), 8'(1 + $urandom % 4));
      if (r < 40) step("R3", 0, 1, 2'd2, d, 0);
      else if (r < 70) step("R2", 1, 0, 2'd2, 8'h00, 0);
      else if (r < 78) step("R9", 1, 0, 2'd1, 8'h00, 0);
      else if (r < 90) step("R7", 0, 0, 2'd0, 8'h00, 1);
      else if (r < 93) step("R11", 0, 1, 2'd1, d, 0);
      else if (r < 97) begin
        if (($urandom % 4) != 0) d[2] = 1'b1;
        step("R12", 0, 1, 2'd0, d, 0);
      end else step("R12", 1, 0, 2'd0, 8'h00, 0);
    end
    finishRun();
  end
endmodule